// File: doc/BRIEF.md
# Serial ADC Host Read Controller

This block is the host side of a three-wire link to a 16-clock serial analog-to-digital converter. It owns the active-low chip select and the serial clock, and reads the converter's data line. Each conversion is one frame: chip select drops and sixteen serial clock falling edges follow. The controller samples the data line once per falling edge, so it collects 16 bits, first bit first. It then drops the four leading bits and the trailing pad bits, and returns a right-aligned result of 12, 10 or 8 bits on a valid/ready response port.

Commands arrive on a valid/ready command port with a 2-bit operation code. A convert command runs a full frame and returns the result. A sleep command starts a frame and ends it early, by raising chip select after a chosen falling edge inside the converter's power-down window. A wake command runs a full frame and throws its data away. After reset the controller runs one such dummy frame on its own before it accepts any command. Between frames chip select is held high for at least a programmable quiet time.

Top module: `adc_rd_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, `adc_cs_n` and `adc_sclk` are 1, and `rsp_valid` and `cmd_ready` are 0.
- R2: After reset, one frame of exactly 16 serial clock falling edges runs without any command. It produces no response. `cmd_ready` rises only after that frame.
- R3: A convert frame (op 0) holds `adc_cs_n` low for exactly 16 falling edges of `adc_sclk`. `adc_sclk` is 1 whenever `adc_cs_n` is 1.
- R4: The controller samples `adc_sdata` just before each falling edge, giving a 16-bit word with the first sample as bit 15. The response is bits 11 down to 12-RES of that word, so the four leading bits never reach the result, whatever their value.
- R5: With RES below 12, the 12-RES trailing bits (bits 11-RES down to 0) are dropped and have no effect on the result.
- R6: A sleep command (op 1) raises `adc_cs_n` right after falling edge number ABORT_EDGE and produces no response. ABORT_EDGE is a parameter limited to 3..9, with a default of 4.
- R7: A wake command (op 2) runs a full 16-edge frame and produces no response.
- R8: From the cycle `adc_cs_n` rises to the cycle it next falls, at least QUIET_CYC clock cycles pass.
- R9: `cmd_ready` is 0 from the accepted command through its frame, the wait for the response to be taken, and the quiet time. No frame runs while `cmd_ready` is 1.
- R10: While `rsp_valid` is 1 and `rsp_ready` is 0, `rsp_valid` stays 1 and `rsp_data` stays unchanged.
- R11: Op 3 is accepted but starts no frame and produces no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_op | input | 2 | 0 convert, 1 sleep, 2 wake, 3 no operation |
| cmd_ready | output | 1 | Command accepted when high with cmd_valid |
| rsp_valid | output | 1 | Result available |
| rsp_ready | input | 1 | Host takes the result |
| rsp_data | output | RES | Right-aligned conversion result |
| adc_cs_n | output | 1 | Converter chip select, active low |
| adc_sclk | output | 1 | Serial clock, idles high |
| adc_sdata | input | 1 | Serial data from converter |

## Verification
The bench builds the controller with CLK_DIV=2, RES=10, ABORT_EDGE=4 and QUIET_CYC=5. With a 10-bit result, both the leading and the trailing bits of the frame must be stripped. A device model drives ones into those positions, so a slice that is off by one place shows up in the result. The short divider keeps each frame near 70 cycles, and a quiet time of 5 makes the gap check meaningful when commands are issued back to back.

// File: rtl/adc_rd_pkg.sv
// Shared definitions for the serial ADC read controller.
// Assumes a converter frame of 16 serial clocks with 4 leading bits.
package adc_rd_pkg;
    typedef enum logic [1:0] {
        OP_CONVERT = 2'd0,
        OP_SLEEP   = 2'd1,
        OP_WAKE    = 2'd2,
        OP_NONE    = 2'd3
    } adc_op_e;

    localparam int FRAME_LEN  = 16;
    localparam int LEAD_BITS  = 4;
    localparam int EDGE_W     = 5;
endpackage

// File: rtl/adc_sclk_div.sv
// Serial clock phase timer: pulses tick once every DIV cycles while run is high.
// Assumes DIV >= 1; the count restarts whenever run is low.
module adc_sclk_div #(
    parameter int DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (DIV < 2) ? 1 : $clog2(DIV + 1);
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    assign tick = run && (cnt == LAST);

    // Phase counter: counts while running, wraps at the end of each phase.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/adc_frame_engine.sv
// Frame engine: drops chip select, produces falling/rising serial clock
// phases on each tick, shifts in one data bit per falling edge, and ends
// the frame after 16 edges or after ABORT_EDGE edges for a short frame.
// Assumes start is only raised while the engine is idle.
module adc_frame_engine
    import adc_rd_pkg::*;
#(
    parameter int ABORT_EDGE = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 short_req,
    input  logic                 tick,
    input  logic                 sdata,
    output logic                 cs_n,
    output logic                 sclk,
    output logic                 active,
    output logic                 done,
    output logic [FRAME_LEN-1:0] frame
);
    typedef enum logic [1:0] {F_IDLE, F_LEAD, F_LOW, F_HIGH} fe_state_e;

    localparam logic [EDGE_W-1:0] FULL_L  = EDGE_W'(FRAME_LEN);
    localparam logic [EDGE_W-1:0] SHORT_L = EDGE_W'(ABORT_EDGE);

    fe_state_e          st;
    logic [EDGE_W-1:0]  edges;
    logic               short_q;
    logic [EDGE_W-1:0]  limit;

    assign limit  = short_q ? SHORT_L : FULL_L;
    assign active = (st != F_IDLE);

    // Frame sequencing: chip select, serial clock phases, sampling, edge count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= F_IDLE;
            cs_n    <= 1'b1;
            sclk    <= 1'b1;
            edges   <= '0;
            short_q <= 1'b0;
            done    <= 1'b0;
            frame   <= '0;
        end else begin
            done <= 1'b0;
            case (st)
                F_IDLE: if (start) begin
                    cs_n    <= 1'b0;
                    edges   <= '0;
                    short_q <= short_req;
                    st      <= F_LEAD;
                end
                F_LEAD: if (tick) begin
                    sclk  <= 1'b0;
                    frame <= {frame[FRAME_LEN-2:0], sdata};
                    edges <= EDGE_W'(1);
                    st    <= F_LOW;
                end
                F_LOW: if (tick) begin
                    sclk <= 1'b1;
                    if (edges == limit) begin
                        cs_n <= 1'b1;
                        done <= 1'b1;
                        st   <= F_IDLE;
                    end else begin
                        st <= F_HIGH;
                    end
                end
                F_HIGH: if (tick) begin
                    sclk  <= 1'b0;
                    frame <= {frame[FRAME_LEN-2:0], sdata};
                    edges <= edges + 1'b1;
                    st    <= F_LOW;
                end
                default: st <= F_IDLE;
            endcase
        end
    end

    // R6
    initial abort_window_chk: assert (ABORT_EDGE > 2 && ABORT_EDGE < 10)
        else $error("ABORT_EDGE outside 3..9");

    // R3
    property p_idle_clk;
        @(posedge clk) disable iff (!rst_n) cs_n |-> sclk;
    endproperty
    idle_clk_chk: assert property (p_idle_clk);

    // R3
    property p_edge_cap;
        @(posedge clk) disable iff (!rst_n) edges <= FULL_L;
    endproperty
    edge_cap_chk: assert property (p_edge_cap);

    // R6
    property p_short_end;
        @(posedge clk) disable iff (!rst_n) ($rose(cs_n) && short_q) |-> (edges == SHORT_L);
    endproperty
    short_end_chk: assert property (p_short_end);
endmodule

// File: rtl/adc_cmd_seq.sv
// Command sequencer: runs the power-on dummy frame, accepts commands,
// turns finished frames into responses or discards them, and holds off
// new commands until the response is taken and the quiet time has passed.
// Assumes the engine raises done for one cycle as chip select rises.
module adc_cmd_seq
    import adc_rd_pkg::*;
#(
    parameter int RES       = 12,
    parameter int QUIET_CYC = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_valid,
    input  logic [1:0]           cmd_op,
    output logic                 cmd_ready,
    output logic                 rsp_valid,
    input  logic                 rsp_ready,
    output logic [RES-1:0]       rsp_data,
    output logic                 eng_start,
    output logic                 eng_short,
    input  logic                 eng_done,
    input  logic [FRAME_LEN-1:0] eng_frame
);
    typedef enum logic [2:0] {Q_BOOT, Q_BUSY, Q_RESP, Q_QUIET, Q_READY} sq_state_e;

    localparam int QW = $clog2(QUIET_CYC + 2) + 1;
    localparam logic [QW-1:0] QMAX = QW'(QUIET_CYC);
    localparam int TOP_BIT = FRAME_LEN - LEAD_BITS - 1;

    sq_state_e   st;
    logic        keep_q;
    logic [QW-1:0] qcnt;
    logic        take;
    adc_op_e     op;

    assign op        = adc_op_e'(cmd_op);
    assign cmd_ready = (st == Q_READY);
    assign take      = cmd_ready && cmd_valid;
    assign eng_start = (st == Q_BOOT) || (take && op != OP_NONE);
    assign eng_short = (st == Q_READY) && (op == OP_SLEEP);

    // Command flow, result capture and quiet-time gating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= Q_BOOT;
            keep_q    <= 1'b0;
            qcnt      <= '0;
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            if (qcnt != QMAX) qcnt <= qcnt + 1'b1;
            case (st)
                Q_BOOT: begin
                    keep_q <= 1'b0;
                    st     <= Q_BUSY;
                end
                Q_BUSY: if (eng_done) begin
                    qcnt <= QW'(1);
                    if (keep_q) begin
                        rsp_data  <= eng_frame[TOP_BIT -: RES];
                        rsp_valid <= 1'b1;
                        st        <= Q_RESP;
                    end else begin
                        st <= Q_QUIET;
                    end
                end
                Q_RESP: if (rsp_ready) begin
                    rsp_valid <= 1'b0;
                    st        <= Q_QUIET;
                end
                Q_QUIET: if (qcnt == QMAX) st <= Q_READY;
                Q_READY: if (take && op != OP_NONE) begin
                    keep_q <= (op == OP_CONVERT);
                    st     <= Q_BUSY;
                end
                default: st <= Q_BOOT;
            endcase
        end
    end

    // R4
    initial res_param_chk: assert (RES == 8 || RES == 10 || RES == 12)
        else $error("RES must be 8, 10 or 12");

    // R10
    property p_rsp_hold;
        @(posedge clk) disable iff (!rst_n)
            (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data));
    endproperty
    rsp_hold_chk: assert property (p_rsp_hold);

    // R9
    property p_ready_excl;
        @(posedge clk) disable iff (!rst_n) cmd_ready |-> !rsp_valid;
    endproperty
    ready_excl_chk: assert property (p_ready_excl);
endmodule

// File: rtl/adc_rd_ctrl.sv
// Top of the serial ADC host read controller: ties the phase timer, the
// frame engine and the command sequencer together.
// Assumes the converter updates its data line after each serial clock fall.
module adc_rd_ctrl
    import adc_rd_pkg::*;
#(
    parameter int CLK_DIV    = 2,
    parameter int RES        = 12,
    parameter int ABORT_EDGE = 4,
    parameter int QUIET_CYC  = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cmd_valid,
    input  logic [1:0]     cmd_op,
    output logic           cmd_ready,
    output logic           rsp_valid,
    input  logic           rsp_ready,
    output logic [RES-1:0] rsp_data,
    output logic           adc_cs_n,
    output logic           adc_sclk,
    input  logic           adc_sdata
);
    localparam int GW = $clog2(QUIET_CYC + 2) + 1;
    localparam logic [GW-1:0] GMAX = GW'(QUIET_CYC);

    logic                 run;
    logic                 tick;
    logic                 start;
    logic                 short_req;
    logic                 done;
    logic [FRAME_LEN-1:0] frame;

    adc_sclk_div #(.DIV(CLK_DIV)) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (run),
        .tick (tick)
    );

    adc_frame_engine #(.ABORT_EDGE(ABORT_EDGE)) u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .short_req(short_req),
        .tick     (tick),
        .sdata    (adc_sdata),
        .cs_n     (adc_cs_n),
        .sclk     (adc_sclk),
        .active   (run),
        .done     (done),
        .frame    (frame)
    );

    adc_cmd_seq #(.RES(RES), .QUIET_CYC(QUIET_CYC)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_valid(cmd_valid),
        .cmd_op   (cmd_op),
        .cmd_ready(cmd_ready),
        .rsp_valid(rsp_valid),
        .rsp_ready(rsp_ready),
        .rsp_data (rsp_data),
        .eng_start(start),
        .eng_short(short_req),
        .eng_done (done),
        .eng_frame(frame)
    );

    // Checker counter: cycles chip select has been high, saturating.
    logic [GW-1:0] gap_q;
    always_ff @(posedge clk) begin
        if (!rst_n) gap_q <= GMAX;
        else if (!adc_cs_n) gap_q <= '0;
        else if (gap_q != GMAX) gap_q <= gap_q + 1'b1;
    end

    // R8
    property p_quiet_gap;
        @(posedge clk) disable iff (!rst_n) $fell(adc_cs_n) |-> (gap_q >= GMAX);
    endproperty
    quiet_gap_chk: assert property (p_quiet_gap);

    // R9
    property p_no_frame_when_ready;
        @(posedge clk) disable iff (!rst_n) cmd_ready |-> adc_cs_n;
    endproperty
    ready_idle_chk: assert property (p_no_frame_when_ready);
endmodule

// File: tb/test_adc_rd_ctrl.sv
`timescale 1ns/1ps
module test_adc_rd_ctrl;
    localparam int CLK_DIV = 2;
    localparam int RES     = 10;
    localparam int ABORT   = 4;
    localparam int QUIET   = 5;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           cmd_valid = 1'b0;
    logic [1:0]     cmd_op = 2'd0;
    logic           cmd_ready;
    logic           rsp_valid;
    logic           rsp_ready = 1'b1;
    logic [RES-1:0] rsp_data;
    logic           adc_cs_n;
    logic           adc_sclk;
    logic           adc_sdata = 1'b1;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    adc_rd_ctrl #(.CLK_DIV(CLK_DIV), .RES(RES), .ABORT_EDGE(ABORT), .QUIET_CYC(QUIET)) i_adc_rd_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_ready(cmd_ready), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_data(rsp_data), .adc_cs_n(adc_cs_n), .adc_sclk(adc_sclk),
        .adc_sdata(adc_sdata)
    );

    // Device model and link monitor
    logic [15:0] dev_word = 16'h0000;
    int  bitpos = 0;
    bit  prev_cs = 1, prev_sclk = 1;
    int  cur_falls = 0, last_falls = 0, frame_cnt = 0;
    int  gap = 0, min_gap = 1000000;
    bit  seen_rise = 0;
    int  idle_clk_viol = 0;
    int  rsp_cnt = 0;
    logic [RES-1:0] last_rsp = '0;

    always @(negedge clk) begin
        if (!rst_n) begin
            prev_cs <= 1; prev_sclk <= 1; adc_sdata <= 1'b1;
        end else begin
            prev_cs <= adc_cs_n;
            prev_sclk <= adc_sclk;
            if (prev_cs && !adc_cs_n) begin
                cur_falls <= 0;
                adc_sdata <= dev_word[15];
                bitpos <= 14;
                if (seen_rise && gap + 1 < min_gap) min_gap <= gap + 1;
            end else if (!adc_cs_n && prev_sclk && !adc_sclk) begin
                cur_falls <= cur_falls + 1;
                adc_sdata <= (bitpos >= 0) ? dev_word[bitpos] : 1'b0;
                bitpos <= bitpos - 1;
            end else if (!prev_cs && adc_cs_n) begin
                last_falls <= cur_falls;
                frame_cnt <= frame_cnt + 1;
                gap <= 0;
                seen_rise <= 1;
                adc_sdata <= 1'b1;
            end else if (adc_cs_n) begin
                gap <= gap + 1;
            end
            if (adc_cs_n && !adc_sclk) idle_clk_viol <= idle_clk_viol + 1;
            if (rsp_valid && rsp_ready) begin
                rsp_cnt <= rsp_cnt + 1;
                last_rsp <= rsp_data;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic wait_ready();
        for (int i = 0; i < 2000 && !cmd_ready; i++) step();
    endtask

    task automatic issue(input logic [1:0] op);
        wait_ready();
        cmd_valid = 1'b1;
        cmd_op = op;
        step();
        cmd_valid = 1'b0;
    endtask

    function automatic logic [15:0] make_word(input logic [3:0] lead,
                                              input logic [RES-1:0] val,
                                              input logic [1:0] trail);
        return {lead, val, trail};
    endfunction

    task automatic t_reset();
        repeat (3) step();
        chk(adc_cs_n == 1'b1, "R1 cs_n", adc_cs_n, 1);
        chk(adc_sclk == 1'b1, "R1 sclk", adc_sclk, 1);
        chk(rsp_valid == 1'b0, "R1 rsp_valid", rsp_valid, 0);
        chk(cmd_ready == 1'b0, "R1 cmd_ready", cmd_ready, 0);
        rst_n = 1'b1;
        step();
        chk(cmd_ready == 1'b0, "R1 ready after reset", cmd_ready, 0);
    endtask

    task automatic t_boot();
        dev_word = 16'hFFFF;
        wait_ready();
        chk(frame_cnt == 1, "R2 boot frame count", frame_cnt, 1);
        chk(last_falls == 16, "R2 boot edges", last_falls, 16);
        chk(rsp_cnt == 0, "R2 boot no response", rsp_cnt, 0);
    endtask

    task automatic t_convert(input logic [3:0] lead, input logic [RES-1:0] val,
                             input logic [1:0] trail, input string req);
        int r0 = rsp_cnt;
        dev_word = make_word(lead, val, trail);
        issue(2'd0);
        for (int i = 0; i < 2000 && rsp_cnt == r0; i++) step();
        chk(rsp_cnt == r0 + 1, {req, " response count"}, rsp_cnt, r0 + 1);
        chk(last_rsp == val, {req, " data"}, last_rsp, val);
        chk(last_falls == 16, "R3 edges per convert", last_falls, 16);
    endtask

    task automatic t_hold();
        int r0 = rsp_cnt;
        logic [RES-1:0] v = 10'h1C3;
        rsp_ready = 1'b0;
        dev_word = make_word(4'h0, v, 2'b00);
        issue(2'd0);
        for (int i = 0; i < 2000 && !rsp_valid; i++) step();
        repeat (12) step();
        chk(rsp_valid == 1'b1, "R10 valid held", rsp_valid, 1);
        chk(rsp_data == v, "R10 data held", rsp_data, v);
        chk(cmd_ready == 1'b0, "R9 not ready while response pending", cmd_ready, 0);
        rsp_ready = 1'b1;
        step();
        chk(rsp_cnt == r0 + 1 && last_rsp == v, "R10 taken once", last_rsp, v);
    endtask

    task automatic t_sleep();
        int f0 = frame_cnt;
        int r0 = rsp_cnt;
        dev_word = 16'hFFFF;
        issue(2'd1);
        wait_ready();
        repeat (4) step();
        chk(frame_cnt == f0 + 1, "R6 one frame", frame_cnt, f0 + 1);
        chk(last_falls == ABORT, "R6 abort edge", last_falls, ABORT);
        chk(last_falls > 2 && last_falls < 10, "R6 inside window", last_falls, ABORT);
        chk(rsp_cnt == r0, "R6 no response", rsp_cnt, r0);
    endtask

    task automatic t_wake();
        int f0 = frame_cnt;
        int r0 = rsp_cnt;
        dev_word = 16'h0ABC;
        issue(2'd2);
        wait_ready();
        repeat (4) step();
        chk(frame_cnt == f0 + 1, "R7 one frame", frame_cnt, f0 + 1);
        chk(last_falls == 16, "R7 full frame", last_falls, 16);
        chk(rsp_cnt == r0, "R7 no response", rsp_cnt, r0);
    endtask

    task automatic t_none();
        int f0 = frame_cnt;
        int r0 = rsp_cnt;
        issue(2'd3);
        repeat (30) step();
        chk(frame_cnt == f0, "R11 no frame", frame_cnt, f0);
        chk(adc_cs_n == 1'b1, "R11 cs idle", adc_cs_n, 1);
        chk(rsp_cnt == r0, "R11 no response", rsp_cnt, r0);
        chk(cmd_ready == 1'b1, "R11 still ready", cmd_ready, 1);
    endtask

    task automatic t_back_to_back();
        dev_word = make_word(4'h0, 10'h0F0, 2'b00);
        issue(2'd0);
        repeat (10) step();
        chk(adc_cs_n == 1'b0, "R9 frame running", adc_cs_n, 0);
        chk(cmd_ready == 1'b0, "R9 not ready mid-frame", cmd_ready, 0);
        issue(2'd2);
        issue(2'd1);
        issue(2'd0);
        wait_ready();
        chk(last_rsp == 10'h0F0, "R4 back-to-back data", last_rsp, 10'h0F0);
    endtask

    initial begin
        t_reset();
        t_boot();
        t_convert(4'h0, 10'h2A5, 2'b00, "R4");
        t_convert(4'hF, 10'h155, 2'b11, "R4 leading ignored");
        t_convert(4'hF, 10'h000, 2'b11, "R5 trailing dropped");
        t_convert(4'h0, 10'h3FF, 2'b00, "R5 full scale");
        t_hold();
        t_sleep();
        t_convert(4'h0, 10'h0A5, 2'b01, "R5 after sleep");
        t_wake();
        t_none();
        t_back_to_back();
        chk(min_gap >= QUIET, "R8 minimum quiet gap", min_gap, QUIET);
        chk(idle_clk_viol == 0, "R3 sclk high while deselected", idle_clk_viol, 0);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule